// File: doc/BRIEF.md
# Dual-Bank Enable Arbiter

This block decides, cycle by cycle, which of two memory banks owns a shared set of address, data and strobe lines. One bank is non-volatile flash and the other is SRAM. The block takes two active-low bank enables, an active-low output enable and an active-low write enable. From them it produces a registered bank select, separate read and write qualifiers for each bank, the address slices each bank sees, and a registered enable for the data-bus drivers.

The flash enable has priority. When both enables are asserted, the flash operation proceeds and the SRAM enable has no effect. Flash writes are refused while output enable is low. SRAM writes ignore output enable.

A parameter selects a pin-sharing variant with one fewer pin. In that variant the output-enable pin is the output enable while flash is enabled, and it is the SRAM enable at all other times. The data-bus drive is held off for one cycle whenever the selected bank changes, so that two banks never drive the bus back to back.

Top module: `dab_arbiter`

## Requirements
- R1: All outputs are registered and reflect the inputs sampled at the previous rising clock edge. While reset is low, every output is 0. `bank_sel` is encoded as 2'b00 for standby, 2'b01 for flash and 2'b10 for SRAM.
- R2: When `fl_en_n` is low, flash is selected regardless of the SRAM enable.
- R3: In the separate-pin variant, with both bank enables high, `bank_sel` is 2'b00 and all qualifiers and `bus_drive` are 0.
- R4: A read qualifier (`fl_rd` or `sr_rd`) is 1 only for the selected bank, with the effective output enable low and `we_n` high.
- R5: `sr_wr` is 1 when SRAM is selected and `we_n` is low, whatever the level of `oe_n`.
- R6: `fl_wr` is 1 only when flash is selected, `we_n` is low and `oe_n` is high. A low `oe_n` inhibits the flash write.
- R7: In the separate-pin variant, `bus_drive` is 0 whenever `oe_n` was high, and it is never 1 without a read qualifier.
- R8: `bus_drive` is 1 only when a read is qualified and the selected bank equals the bank selected in the previous cycle. On a bank change it stays 0 for that cycle.
- R9: With `SHARED_PIN`=1, the `oe_n` pin acts as output enable while `fl_en_n` is low. While `fl_en_n` is high, a low `oe_n` selects SRAM, and an SRAM read needs only `we_n` high.
- R10: `sr_addr` carries the low `SR_AW` bits of `addr`, so SRAM aliases into the bottom of the space. `fl_addr` carries all `FL_AW` bits.
- R11: With `SHARED_PIN`=1, `sr_en_n` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fl_en_n | input | 1 | Flash bank enable, active low |
| sr_en_n | input | 1 | SRAM bank enable, active low (unused in shared-pin variant) |
| oe_n | input | 1 | Output enable, active low; doubles as SRAM enable in shared-pin variant |
| we_n | input | 1 | Write enable, active low |
| addr | input | FL_AW | Shared address |
| bank_sel | output | 2 | Selected bank: 00 none, 01 flash, 10 SRAM |
| fl_rd | output | 1 | Flash read qualifier |
| fl_wr | output | 1 | Flash write qualifier |
| sr_rd | output | 1 | SRAM read qualifier |
| sr_wr | output | 1 | SRAM write qualifier |
| bus_drive | output | 1 | Data-bus output drive enable |
| fl_addr | output | FL_AW | Registered flash address |
| sr_addr | output | SR_AW | Registered SRAM address (low bits) |

## Verification
The bench covers the following corner cases:
- **Both enables low.** A design without flash priority would select SRAM or raise both selects.
- **Flash write with output enable low.** A design that skips this check would issue a flash write that should be inhibited.
- **SRAM write with output enable in either state.** This exposes a design that wrongly gates SRAM writes on output enable.
- **Flash-to-SRAM and SRAM-to-flash switches during continuous reads.** A design without the drive gating would assert `bus_drive` in the switch cycle.

The shared-pin variant is driven with the same stimulus. In that variant a wrong pin-role mapping shows up as a wrong select, or as `sr_en_n` leaking through.

// File: rtl/dab_pkg.sv
// Package: shared types for the dual-bank enable arbiter.
// Assumes: banks are encoded one-hot so that standby is all zero.
package dab_pkg;
    typedef enum logic [1:0] {
        BANK_NONE  = 2'b00,
        BANK_FLASH = 2'b01,
        BANK_SRAM  = 2'b10
    } bank_e;
endpackage

// File: rtl/dab_role_map.sv
// Module: dab_role_map
// Maps the raw pins onto effective active-high bank requests and an
// effective active-low output enable. A parameter picks the separate-pin
// or shared-pin variant.
// Assumes: inputs are already synchronous to clk.
module dab_role_map #(
    parameter bit SHARED_PIN = 1'b0
) (
    input  logic fl_en_n,
    input  logic sr_en_n,
    input  logic oe_n,
    output logic fl_req,
    output logic sr_req,
    output logic oe_eff_n
);
    // Flash request is the same in both variants
    assign fl_req = ~fl_en_n;

    generate
        if (SHARED_PIN) begin : g_shared
            logic unused_sr_en;
            // The SRAM enable pin is not wired in this variant
            assign unused_sr_en = sr_en_n;
            // The shared pin enables SRAM when flash is off
            assign sr_req   = fl_en_n & ~oe_n;
            // In SRAM mode the enable itself gates the output
            assign oe_eff_n = fl_en_n ? 1'b0 : oe_n;
        end else begin : g_separate
            // Separate pins: SRAM enable and output enable pass through
            assign sr_req   = ~sr_en_n;
            assign oe_eff_n = oe_n;
        end
    endgenerate
endmodule

// File: rtl/dab_decode.sv
// Module: dab_decode
// Combinational bank priority and read/write qualification.
// Assumes: requests are active high; flash has priority over SRAM.
module dab_decode
    import dab_pkg::*;
(
    input  logic  fl_req,
    input  logic  sr_req,
    input  logic  oe_eff_n,
    input  logic  we_n,
    output bank_e bank,
    output logic  fl_rd,
    output logic  fl_wr,
    output logic  sr_rd,
    output logic  sr_wr
);
    logic fl_sel;
    logic sr_sel;

    // Priority select: flash dominates
    always_comb begin
        fl_sel = fl_req;
        sr_sel = sr_req & ~fl_req;
        if (fl_sel)      bank = BANK_FLASH;
        else if (sr_sel) bank = BANK_SRAM;
        else             bank = BANK_NONE;
    end

    // Qualify reads and writes per bank
    always_comb begin
        fl_rd = fl_sel & ~oe_eff_n & we_n;
        sr_rd = sr_sel & ~oe_eff_n & we_n;
        fl_wr = fl_sel & ~we_n & oe_eff_n;
        sr_wr = sr_sel & ~we_n;
    end
endmodule

// File: rtl/dab_out_reg.sv
// Module: dab_out_reg
// Output register stage. It holds back the bus drive on any cycle in which
// the selected bank differs from the one registered before.
// Assumes: synchronous active-low reset, outputs zero in reset.
module dab_out_reg
    import dab_pkg::*;
#(
    parameter int FL_AW = 19,
    parameter int SR_AW = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bank_e            bank_d,
    input  logic             fl_rd_d,
    input  logic             fl_wr_d,
    input  logic             sr_rd_d,
    input  logic             sr_wr_d,
    input  logic [FL_AW-1:0] addr_d,
    output bank_e            bank_q,
    output logic             fl_rd_q,
    output logic             fl_wr_q,
    output logic             sr_rd_q,
    output logic             sr_wr_q,
    output logic             drive_q,
    output logic [FL_AW-1:0] fl_addr_q,
    output logic [SR_AW-1:0] sr_addr_q
);
    logic drive_d;

    // Drive only on a read to the same bank as last cycle
    always_comb begin
        drive_d = (fl_rd_d | sr_rd_d) & (bank_d == bank_q);
    end

    // Register all outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q    <= BANK_NONE;
            fl_rd_q   <= 1'b0;
            fl_wr_q   <= 1'b0;
            sr_rd_q   <= 1'b0;
            sr_wr_q   <= 1'b0;
            drive_q   <= 1'b0;
            fl_addr_q <= '0;
            sr_addr_q <= '0;
        end else begin
            bank_q    <= bank_d;
            fl_rd_q   <= fl_rd_d;
            fl_wr_q   <= fl_wr_d;
            sr_rd_q   <= sr_rd_d;
            sr_wr_q   <= sr_wr_d;
            drive_q   <= drive_d;
            fl_addr_q <= addr_d;
            sr_addr_q <= addr_d[SR_AW-1:0];
        end
    end
endmodule

// File: rtl/dab_arbiter.sv
// Module: dab_arbiter (top)
// Arbitrates a flash bank and an SRAM bank that share address, data and
// strobes, and registers the selects, qualifiers, addresses and bus drive.
// Assumes: SR_AW <= FL_AW; SRAM sits at the bottom of the address space.
module dab_arbiter
    import dab_pkg::*;
#(
    parameter bit SHARED_PIN = 1'b0,
    parameter int FL_AW      = 19,
    parameter int SR_AW      = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fl_en_n,
    input  logic             sr_en_n,
    input  logic             oe_n,
    input  logic             we_n,
    input  logic [FL_AW-1:0] addr,
    output logic [1:0]       bank_sel,
    output logic             fl_rd,
    output logic             fl_wr,
    output logic             sr_rd,
    output logic             sr_wr,
    output logic             bus_drive,
    output logic [FL_AW-1:0] fl_addr,
    output logic [SR_AW-1:0] sr_addr
);
    logic  fl_req, sr_req, oe_eff_n;
    bank_e bank_d, bank_q;
    logic  fl_rd_d, fl_wr_d, sr_rd_d, sr_wr_d;

    dab_role_map #(.SHARED_PIN(SHARED_PIN)) u_role (
        .fl_en_n (fl_en_n),
        .sr_en_n (sr_en_n),
        .oe_n    (oe_n),
        .fl_req  (fl_req),
        .sr_req  (sr_req),
        .oe_eff_n(oe_eff_n)
    );

    dab_decode u_dec (
        .fl_req  (fl_req),
        .sr_req  (sr_req),
        .oe_eff_n(oe_eff_n),
        .we_n    (we_n),
        .bank    (bank_d),
        .fl_rd   (fl_rd_d),
        .fl_wr   (fl_wr_d),
        .sr_rd   (sr_rd_d),
        .sr_wr   (sr_wr_d)
    );

    dab_out_reg #(.FL_AW(FL_AW), .SR_AW(SR_AW)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .bank_d   (bank_d),
        .fl_rd_d  (fl_rd_d),
        .fl_wr_d  (fl_wr_d),
        .sr_rd_d  (sr_rd_d),
        .sr_wr_d  (sr_wr_d),
        .addr_d   (addr),
        .bank_q   (bank_q),
        .fl_rd_q  (fl_rd),
        .fl_wr_q  (fl_wr),
        .sr_rd_q  (sr_rd),
        .sr_wr_q  (sr_wr),
        .drive_q  (bus_drive),
        .fl_addr_q(fl_addr),
        .sr_addr_q(sr_addr)
    );

    // Expose the bank as a plain vector
    assign bank_sel = bank_q;
endmodule

// File: rtl/dab_arbiter_chk.sv
// Module: dab_arbiter_chk
// Property checker for dab_arbiter, attached by bind below.
// Assumes: rst_n is low at time zero.
module dab_arbiter_chk #(
    parameter bit SHARED_PIN = 1'b0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       fl_en_n,
    input logic       sr_en_n,
    input logic       oe_n,
    input logic       we_n,
    input logic [1:0] bank_sel,
    input logic       fl_rd,
    input logic       fl_wr,
    input logic       sr_rd,
    input logic       sr_wr,
    input logic       bus_drive
);
    p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_sel));

    p_flash_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_en_n |=> (bank_sel == 2'b01));

    p_standby_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!SHARED_PIN && fl_en_n && sr_en_n) |=>
            (bank_sel == 2'b00 && !fl_rd && !sr_rd && !fl_wr && !sr_wr && !bus_drive));

    p_rd_needs_we_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> (!fl_rd && !sr_rd));

    p_flash_wr_inhibit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |=> !fl_wr);

    p_oe_high_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!SHARED_PIN && oe_n) |=> !bus_drive);

    p_drive_with_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive |-> (fl_rd || sr_rd));

    p_no_drive_on_switch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_sel != $past(bank_sel)) |-> !bus_drive);

    p_shared_oe_role_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (SHARED_PIN && fl_en_n && !oe_n) |=> (bank_sel == 2'b10));

    p_rw_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({fl_rd, fl_wr, sr_rd, sr_wr}) <= 1);
endmodule

bind dab_arbiter dab_arbiter_chk #(.SHARED_PIN(SHARED_PIN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fl_en_n  (fl_en_n),
    .sr_en_n  (sr_en_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .bank_sel (bank_sel),
    .fl_rd    (fl_rd),
    .fl_wr    (fl_wr),
    .sr_rd    (sr_rd),
    .sr_wr    (sr_wr),
    .bus_drive(bus_drive)
);

// File: tb/dab_arbiter_bench.sv
// Scoreboard bench: the driver pushes expected results for both variants,
// and the monitor pops and compares them after each rising edge.
module dab_arbiter_bench;
    localparam int FL_AW = 19;
    localparam int SR_AW = 17;

    typedef struct {
        logic [6:0]       exp_a;
        logic [6:0]       exp_b;
        logic [FL_AW-1:0] exp_fa;
        logic [SR_AW-1:0] exp_sa;
        string            tag_a;
        string            tag_b;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fl_en_n = 1'b1, sr_en_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [FL_AW-1:0] addr = '0;

    logic [1:0] sel_a, sel_b;
    logic flr_a, flw_a, srr_a, srw_a, drv_a;
    logic flr_b, flw_b, srr_b, srw_b, drv_b;
    logic [FL_AW-1:0] fa_a, fa_b;
    logic [SR_AW-1:0] sa_a, sa_b;

    int checks = 0;
    int errors = 0;
    item_t q[$];
    logic [1:0] prev_a = 2'b00;
    logic [1:0] prev_b = 2'b00;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dab_arbiter #(.SHARED_PIN(1'b0), .FL_AW(FL_AW), .SR_AW(SR_AW)) u_dab_arbiter (
        .clk(clk), .rst_n(rst_n), .fl_en_n(fl_en_n), .sr_en_n(sr_en_n),
        .oe_n(oe_n), .we_n(we_n), .addr(addr), .bank_sel(sel_a),
        .fl_rd(flr_a), .fl_wr(flw_a), .sr_rd(srr_a), .sr_wr(srw_a),
        .bus_drive(drv_a), .fl_addr(fa_a), .sr_addr(sa_a));

    dab_arbiter #(.SHARED_PIN(1'b1), .FL_AW(FL_AW), .SR_AW(SR_AW)) u_dab_arbiter_shared (
        .clk(clk), .rst_n(rst_n), .fl_en_n(fl_en_n), .sr_en_n(sr_en_n),
        .oe_n(oe_n), .we_n(we_n), .addr(addr), .bank_sel(sel_b),
        .fl_rd(flr_b), .fl_wr(flw_b), .sr_rd(srr_b), .sr_wr(srw_b),
        .bus_drive(drv_b), .fl_addr(fa_b), .sr_addr(sa_b));

    // Reference model: {bank[1:0], fl_rd, fl_wr, sr_rd, sr_wr, drive}
    function automatic logic [6:0] model(bit shared, logic f, logic s, logic o,
                                         logic w, ref logic [1:0] prev);
        logic fl, sr, oe_eff, rd;
        logic [1:0] bank;
        fl = !f;
        if (shared) begin
            sr = f && !o;
            oe_eff = f ? 1'b0 : o;
        end else begin
            sr = f && !s;
            oe_eff = o;
        end
        bank = fl ? 2'b01 : (sr ? 2'b10 : 2'b00);
        rd = (bank != 2'b00) && !oe_eff && w;
        model = {bank, rd && fl, fl && !w && oe_eff, rd && !fl, (bank == 2'b10) && !w,
                 rd && (bank == prev)};
        prev = bank;
    endfunction

    // Drive one cycle of stimulus and push its expectation
    task automatic step(input logic r, input logic f, input logic s, input logic o,
                        input logic w, input logic [FL_AW-1:0] a,
                        input string ta, input string tb);
        item_t it;
        @(negedge clk);
        rst_n = r; fl_en_n = f; sr_en_n = s; oe_n = o; we_n = w; addr = a;
        if (!r) begin
            it.exp_a = '0; it.exp_b = '0; it.exp_fa = '0; it.exp_sa = '0;
            prev_a = 2'b00; prev_b = 2'b00;
        end else begin
            it.exp_a = model(1'b0, f, s, o, w, prev_a);
            it.exp_b = model(1'b1, f, s, o, w, prev_b);
            it.exp_fa = a;
            it.exp_sa = a[SR_AW-1:0];
        end
        it.tag_a = ta; it.tag_b = tb;
        q.push_back(it);
    endtask

    // Monitor: compare after each rising edge, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                item_t it;
                logic [6:0] act_a, act_b;
                it = q.pop_front();
                act_a = {sel_a, flr_a, flw_a, srr_a, srw_a, drv_a};
                act_b = {sel_b, flr_b, flw_b, srr_b, srw_b, drv_b};
                checks += 2;
                if (act_a !== it.exp_a) begin
                    errors++;
                    $display("FAIL %s separate: actual %b expected %b", it.tag_a, act_a, it.exp_a);
                end
                if (act_b !== it.exp_b) begin
                    errors++;
                    $display("FAIL %s shared: actual %b expected %b", it.tag_b, act_b, it.exp_b);
                end
                checks++;
                if (fa_a !== it.exp_fa || sa_a !== it.exp_sa || sa_b !== it.exp_sa) begin
                    errors++;
                    $display("FAIL R10 addr: actual %h/%h expected %h/%h",
                             fa_a, sa_a, it.exp_fa, it.exp_sa);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // Reset with a read-like input pattern: R1 outputs stay zero
        repeat (3) step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 19'h1234, "R1", "R1");
        // Standby, separate pins; shared variant sees SRAM via oe pin (R9)
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 19'h00010, "R3", "R9");
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 19'h00011, "R3", "R9");
        // Flash read: first cycle after switch, then steady (R8, R4)
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 19'h7ABCD, "R8", "R8");
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 19'h7ABCE, "R4", "R4");
        // Both enables low: flash keeps the bus (R2)
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 19'h4FFFF, "R2", "R2");
        // SRAM read after flash: switch cycle, then steady
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 19'h3FFFF, "R8", "R8");
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 19'h20001, "R4", "R11");
        // SRAM enabled, output enable high: no read, no drive (R7)
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 19'h00002, "R7", "R11");
        // SRAM writes with oe low and high (R5)
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 19'h00003, "R5", "R9");
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 19'h00004, "R5", "R11");
        // Back to flash read from SRAM: switch gating (R8)
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 19'h00005, "R4", "R9");
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 19'h00006, "R8", "R8");
        // Flash write allowed, then inhibited by oe low (R6)
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 19'h55555, "R6", "R6");
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 19'h2AAAA, "R6", "R6");
        // Both enables low with write: flash write, not SRAM (R2)
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 19'h12345, "R2", "R2");
        // Shared variant ignores sr_en_n (R11)
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 19'h0FFFF, "R3", "R11");
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 19'h6ABCD, "R3", "R11");
        // Flash read with oe high: bus stays off (R7)
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 19'h7FFFF, "R7", "R7");
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 19'h00000, "R3", "R9");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule